// File: doc/BRIEF.md
# DMA Channel Interrupt and Completion Accounting Unit

This unit collects the event pulses raised by one DMA channel into a twelve-bit sticky status word, filters them through a mask, and drives one level-sensitive interrupt line. Software reaches it through a simple word-addressed register port. Status bits are cleared by writing ones to them. The mask cannot be written directly. It is changed only through two write-only strobe registers: one unmasks the chosen sources and the other masks them.

Alongside the status word, the unit keeps two completion counters. One counts finished source descriptors and the other counts finished destination descriptors. Reading a counter returns its value and clears it. A counter that is incremented past its top value wraps to zero and raises its own accounting-error status bit, so software learns that completions were lost between two reads. Any access to an address outside the map is flagged in the status word.

Top module: `dma_irq_acct`

## Requirements
- R1: After reset the status word reads 0, the mask reads 0xFFF (every source masked), both counters read 0 and `irq` is low.
- R2: A one-cycle pulse on `ev_pulse[i]` sets status bit i from the next cycle on. Bit meanings, from bit 0 up, are:
  - 0: bad register access
  - 1: source descriptor finished
  - 2: destination descriptor finished
  - 3: byte-count overflow
  - 4: source accounting error
  - 5: destination accounting error
  - 6: source descriptor fetch error
  - 7: destination descriptor fetch error
  - 8: data read error
  - 9: data write error
  - 10: transfer complete
  - 11: channel paused
- R3: The status word is at word address 0. Writing a 1 to a bit clears that bit, and writing a 0 leaves it unchanged. Bits 31:12 always read 0.
- R4: The mask is read at word address 1. A write to address 1 leaves the mask unchanged.
- R5: Writing a 1 to a bit at word address 2 clears that mask bit. Writing a 1 to a bit at word address 3 sets that mask bit. Both addresses read back 0.
- R6: `irq` is high exactly when some status bit is set and its mask bit is clear. The output is combinational from the registered state when `IRQ_REG` is 0.
- R7: `ev_pulse[1]` increments the source counter, read at word address 4. `ev_pulse[2]` increments the destination counter, read at word address 5. A read returns the current count and clears it to 0.
- R8: An increment of a counter holding 255 wraps it to 0. It also sets status bit 4 (source counter) or status bit 5 (destination counter).
- R9: A read or write to any word address above 5 sets status bit 0. Such a read returns 0, and such a write changes no state.
- R10: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R11: A clearing read of a counter in the same cycle as its increment returns the old count and leaves the counter at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_pulse | input | NUM_EV | One-cycle event pulses from the channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects happen at the clock edge |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational while `reg_rd` is high, zero otherwise |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the unit with its default parameters: twelve events, 8-bit counters and a combinational interrupt output. With the 8-bit width, a run of 256 completion pulses reaches both counter wraps in a few hundred cycles. With the combinational output, `irq` can be compared against the expected pending state in the same cycle as every register read. A table walks through set, clear, mask, strobe and address-decode cases. Directed tests then cover the same-cycle collisions, the counter wraps and a mid-run reset.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   // Status bit positions
   localparam int EV_BADREG = 0;
   localparam int EV_SDONE  = 1;
   localparam int EV_DDONE  = 2;
   localparam int EV_BCNT   = 3;
   localparam int EV_SACCT  = 4;
   localparam int EV_DACCT  = 5;
   localparam int EV_SDFERR = 6;
   localparam int EV_DDFERR = 7;
   localparam int EV_RDERR  = 8;
   localparam int EV_WRERR  = 9;
   localparam int EV_XFER   = 10;
   localparam int EV_PAUSE  = 11;
   localparam int EV_MIN    = 12;

   // Word addresses
   localparam int A_STAT = 0;
   localparam int A_MASK = 1;
   localparam int A_UNMS = 2;
   localparam int A_MSK  = 3;
   localparam int A_SCNT = 4;
   localparam int A_DCNT = 5;
   localparam int A_LAST = 5;

   // Counter slot indices
   localparam int CNT_SRC = 0;
   localparam int CNT_DST = 1;
   localparam int NUM_CNT = 2;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
   parameter int N = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o
);
   // A set takes priority over a clear of the same bit in one cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_o <= '0;
      else        stat_o <= (stat_o & ~clr_i) | set_i;
   end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int N = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] unmask_i,
   input  logic [N-1:0] mask_i,
   output logic [N-1:0] mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_o <= '1;
      else        mask_o <= (mask_o & ~unmask_i) | mask_i;
   end
endmodule

// File: rtl/irq_acct_counter.sv
module irq_acct_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             rdclr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // A wrap only counts when no clearing read hides it.
   assign wrap_o = inc_i && !rdclr_i && (cnt_o == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_o <= '0;
      else if (rdclr_i) cnt_o <= inc_i ? ONE : '0;
      else if (inc_i)   cnt_o <= cnt_o + ONE;
   end
endmodule

// File: rtl/dma_irq_acct.sv
module dma_irq_acct
   import dma_irq_pkg::*;
#(
   parameter int NUM_EV  = 12,
   parameter int CNT_W   = 8,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EV-1:0] ev_pulse,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   // Elaboration-time parameter checks
   if (NUM_EV < EV_MIN || NUM_EV > DATA_W) begin : g_bad_ev
      $error("NUM_EV must lie between %0d and DATA_W", EV_MIN);
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie between 1 and DATA_W");
   end
   if (ADDR_SPAN <= A_LAST) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   // Address decode
   logic hit_stat, hit_mask, hit_unms, hit_msk, hit_scnt, hit_dcnt;
   logic mapped, bad_acc;

   assign hit_stat = (reg_addr == ADDR_W'(A_STAT));
   assign hit_mask = (reg_addr == ADDR_W'(A_MASK));
   assign hit_unms = (reg_addr == ADDR_W'(A_UNMS));
   assign hit_msk  = (reg_addr == ADDR_W'(A_MSK));
   assign hit_scnt = (reg_addr == ADDR_W'(A_SCNT));
   assign hit_dcnt = (reg_addr == ADDR_W'(A_DCNT));
   assign mapped   = hit_stat | hit_mask | hit_unms | hit_msk | hit_scnt | hit_dcnt;
   assign bad_acc  = (reg_wr | reg_rd) & ~mapped;

   // Write data bits above the event field have no destination.
   logic wdata_unused;
   if (DATA_W > NUM_EV) begin : g_wd_hi
      assign wdata_unused = ^reg_wdata[DATA_W-1:NUM_EV];
   end else begin : g_wd_none
      assign wdata_unused = 1'b0;
   end

   // Completion counters
   logic [NUM_CNT-1:0] cnt_inc, cnt_clr, cnt_wrap;
   logic [CNT_W-1:0]   acct_cnt [NUM_CNT];
   logic [CNT_W-1:0]   src_cnt, dst_cnt;

   assign cnt_inc[CNT_SRC] = ev_pulse[EV_SDONE];
   assign cnt_inc[CNT_DST] = ev_pulse[EV_DDONE];
   assign cnt_clr[CNT_SRC] = reg_rd & hit_scnt;
   assign cnt_clr[CNT_DST] = reg_rd & hit_dcnt;

   for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
      irq_acct_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc_i   (cnt_inc[c]),
         .rdclr_i (cnt_clr[c]),
         .cnt_o   (acct_cnt[c]),
         .wrap_o  (cnt_wrap[c])
      );
   end

   assign src_cnt = acct_cnt[CNT_SRC];
   assign dst_cnt = acct_cnt[CNT_DST];

   // Status word
   logic [NUM_EV-1:0] stat_set, stat_clr, stat_q;

   always_comb begin
      stat_set            = ev_pulse;
      stat_set[EV_SACCT]  = ev_pulse[EV_SACCT]  | cnt_wrap[CNT_SRC];
      stat_set[EV_DACCT]  = ev_pulse[EV_DACCT]  | cnt_wrap[CNT_DST];
      stat_set[EV_BADREG] = ev_pulse[EV_BADREG] | bad_acc;
   end

   assign stat_clr = (reg_wr && hit_stat) ? reg_wdata[NUM_EV-1:0] : '0;

   irq_stat_bank #(.N(NUM_EV)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (stat_set),
      .clr_i  (stat_clr),
      .stat_o (stat_q)
   );

   // Mask, changed only through the strobe addresses
   logic [NUM_EV-1:0] unms_bits, msk_bits, mask_q;

   assign unms_bits = (reg_wr && hit_unms) ? reg_wdata[NUM_EV-1:0] : '0;
   assign msk_bits  = (reg_wr && hit_msk)  ? reg_wdata[NUM_EV-1:0] : '0;

   irq_mask_bank #(.N(NUM_EV)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .unmask_i (unms_bits),
      .mask_i   (msk_bits),
      .mask_o   (mask_q)
   );

   // Read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         if (hit_stat)      reg_rdata = DATA_W'(stat_q);
         else if (hit_mask) reg_rdata = DATA_W'(mask_q);
         else if (hit_scnt) reg_rdata = DATA_W'(src_cnt);
         else if (hit_dcnt) reg_rdata = DATA_W'(dst_cnt);
      end
   end

   // Interrupt output, combinational or registered
   logic pending;
   assign pending = |(stat_q & ~mask_q);

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pending;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = pending;
   end
endmodule

// File: rtl/dma_irq_acct_chk.sv
module dma_irq_acct_chk
   import dma_irq_pkg::*;
#(
   parameter int NUM_EV = 12,
   parameter int CNT_W  = 8,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_EV-1:0] ev_pulse,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NUM_EV-1:0] stat_q,
   input logic [NUM_EV-1:0] mask_q,
   input logic [CNT_W-1:0]  src_cnt,
   input logic [CNT_W-1:0]  dst_cnt
);
   logic unmapped;
   assign unmapped = (int'(reg_addr) > A_LAST);

   // R2 / R10: every pulsed bit is set in the following cycle.
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_pulse) |=> ((stat_q & $past(ev_pulse)) == $past(ev_pulse)));

   // R5: the unmask strobe clears the written bits.
   a_r5_unmask: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(A_UNMS))
      |=> ((mask_q & $past(reg_wdata[NUM_EV-1:0])) == '0));

   // R5: the mask strobe sets the written bits.
   a_r5_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(A_MSK))
      |=> ((mask_q & $past(reg_wdata[NUM_EV-1:0])) == $past(reg_wdata[NUM_EV-1:0])));

   // R4: writes to the mask address do not move the mask.
   a_r4_mask_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(A_MASK)) |=> $stable(mask_q));

   // R9: a bad access flags bit 0, and a bad read returns zero.
   a_r9_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_wr || reg_rd) && unmapped) |=> stat_q[EV_BADREG]);
   a_r9_rdzero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && unmapped) |-> (reg_rdata == '0));

   // R8: the source counter wraps and flags its accounting error.
   a_r8_src_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (src_cnt == '1 && ev_pulse[EV_SDONE] && !(reg_rd && reg_addr == ADDR_W'(A_SCNT)))
      |=> (src_cnt == '0 && stat_q[EV_SACCT]));

   // R8: the destination counter wraps and flags its accounting error.
   a_r8_dst_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_cnt == '1 && ev_pulse[EV_DDONE] && !(reg_rd && reg_addr == ADDR_W'(A_DCNT)))
      |=> (dst_cnt == '0 && stat_q[EV_DACCT]));

   // R11: a clearing read together with an increment leaves the count at 1.
   a_r11_src_rdinc: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(A_SCNT) && ev_pulse[EV_SDONE])
      |=> (src_cnt == CNT_W'(1)));
endmodule

bind dma_irq_acct dma_irq_acct_chk #(
   .NUM_EV (NUM_EV),
   .CNT_W  (CNT_W),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_pulse  (ev_pulse),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .stat_q    (stat_q),
   .mask_q    (mask_q),
   .src_cnt   (src_cnt),
   .dst_cnt   (dst_cnt)
);

// File: tb/dma_irq_acct_test.sv
`timescale 1ns/100ps
module dma_irq_acct_test;
   localparam logic [1:0] K_WR = 2'd0;
   localparam logic [1:0] K_RD = 2'd1;
   localparam logic [1:0] K_EV = 2'd2;

   typedef struct packed {
      logic [1:0]  kind;
      logic [3:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic        exp_irq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 34;
   localparam vec_t VEC [NV] = '{
      '{K_RD, 4'd0, 32'h0,        32'h0,   1'b0, 4'd1},  // R1 status
      '{K_RD, 4'd1, 32'h0,        32'hFFF, 1'b0, 4'd1},  // R1 mask
      '{K_RD, 4'd4, 32'h0,        32'h0,   1'b0, 4'd1},  // R1 src count
      '{K_RD, 4'd5, 32'h0,        32'h0,   1'b0, 4'd1},  // R1 dst count
      '{K_EV, 4'd0, 32'h400,      32'h0,   1'b0, 4'd2},  // R2 transfer complete
      '{K_RD, 4'd0, 32'h0,        32'h400, 1'b0, 4'd2},  // R2
      '{K_WR, 4'd2, 32'h400,      32'h0,   1'b0, 4'd5},  // R5 unmask
      '{K_RD, 4'd1, 32'h0,        32'hBFF, 1'b1, 4'd6},  // R6
      '{K_RD, 4'd2, 32'h0,        32'h0,   1'b1, 4'd5},  // R5 reads zero
      '{K_RD, 4'd3, 32'h0,        32'h0,   1'b1, 4'd5},  // R5 reads zero
      '{K_WR, 4'd1, 32'h0,        32'h0,   1'b0, 4'd4},  // R4 write ignored
      '{K_RD, 4'd1, 32'h0,        32'hBFF, 1'b1, 4'd4},  // R4
      '{K_WR, 4'd0, 32'h400,      32'h0,   1'b0, 4'd3},  // R3 w1c
      '{K_RD, 4'd0, 32'h0,        32'h0,   1'b0, 4'd3},  // R3
      '{K_EV, 4'd0, 32'h800,      32'h0,   1'b0, 4'd2},  // R2 pause
      '{K_RD, 4'd0, 32'h0,        32'h800, 1'b0, 4'd6},  // R6 masked
      '{K_WR, 4'd2, 32'h800,      32'h0,   1'b0, 4'd5},  // R5
      '{K_RD, 4'd1, 32'h0,        32'h3FF, 1'b1, 4'd6},  // R6
      '{K_WR, 4'd3, 32'hC00,      32'h0,   1'b0, 4'd5},  // R5 mask strobe
      '{K_RD, 4'd1, 32'h0,        32'hFFF, 1'b0, 4'd5},  // R5
      '{K_EV, 4'd0, 32'h002,      32'h0,   1'b0, 4'd7},  // R7
      '{K_EV, 4'd0, 32'h006,      32'h0,   1'b0, 4'd7},  // R7
      '{K_RD, 4'd4, 32'h0,        32'h2,   1'b0, 4'd7},  // R7 src count
      '{K_RD, 4'd4, 32'h0,        32'h0,   1'b0, 4'd7},  // R7 cleared
      '{K_RD, 4'd5, 32'h0,        32'h1,   1'b0, 4'd7},  // R7 dst count
      '{K_RD, 4'd0, 32'h0,        32'h806, 1'b0, 4'd2},  // R2
      '{K_WR, 4'd0, 32'hFFFFFFFF, 32'h0,   1'b0, 4'd3},  // R3
      '{K_RD, 4'd0, 32'h0,        32'h0,   1'b0, 4'd3},  // R3
      '{K_RD, 4'd9, 32'h0,        32'h0,   1'b0, 4'd9},  // R9 bad read
      '{K_RD, 4'd0, 32'h0,        32'h001, 1'b0, 4'd9},  // R9
      '{K_WR, 4'd0, 32'h1,        32'h0,   1'b0, 4'd3},  // R3
      '{K_WR, 4'd14, 32'hFFF,     32'h0,   1'b0, 4'd9},  // R9 bad write
      '{K_RD, 4'd1, 32'h0,        32'hFFF, 1'b0, 4'd9},  // R9 no effect
      '{K_RD, 4'd0, 32'h0,        32'h001, 1'b0, 4'd9}   // R9
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] ev_pulse = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dma_irq_acct uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_pulse  (ev_pulse),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse(input logic [11:0] e);
      ev_pulse = e;
      @(negedge clk);
      ev_pulse = '0;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         case (VEC[i].kind)
            K_WR: wr(VEC[i].addr, VEC[i].data);
            K_EV: pulse(VEC[i].data[11:0]);
            default: begin
               reg_rd = 1'b1; reg_addr = VEC[i].addr;
               #1;
               check($sformatf("R%0d vec %0d rdata", VEC[i].req, i), reg_rdata, VEC[i].exp);
               check($sformatf("R%0d vec %0d irq", VEC[i].req, i), {31'b0, irq}, {31'b0, VEC[i].exp_irq});
               @(negedge clk);
               reg_rd = 1'b0;
            end
         endcase
      end

      // R10: set and clear of bit 3 in the same cycle
      wr(4'd0, 32'hFFF);
      ev_pulse = 12'h008; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h008;
      @(negedge clk);
      ev_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
      rd(4'd0, v); check("R10 set wins", v, 32'h008);

      // R6: unmasking an already pending bit raises irq, clearing drops it
      wr(4'd2, 32'h008);
      #1 check("R6 irq after unmask", {31'b0, irq}, 32'h1);
      @(negedge clk);
      wr(4'd0, 32'h008);
      #1 check("R6 irq after clear", {31'b0, irq}, 32'h0);
      @(negedge clk);
      wr(4'd3, 32'h008);

      // R8: 256 source completions wrap the source counter
      for (int k = 0; k < 256; k++) pulse(12'h002);
      rd(4'd4, v); check("R8 src wrap count", v, 32'h0);
      rd(4'd0, v); check("R8 src acct flag", v, 32'h012);
      for (int k = 0; k < 256; k++) pulse(12'h004);
      rd(4'd5, v); check("R8 dst wrap count", v, 32'h0);
      rd(4'd0, v); check("R8 dst acct flag", v, 32'h036);
      wr(4'd0, 32'hFFF);

      // R11: clearing read collides with an increment
      for (int k = 0; k < 3; k++) pulse(12'h002);
      reg_rd = 1'b1; reg_addr = 4'd4; ev_pulse = 12'h002;
      #1 check("R11 read returns old count", reg_rdata, 32'h3);
      @(negedge clk);
      reg_rd = 1'b0; ev_pulse = '0;
      rd(4'd4, v); check("R11 count left at 1", v, 32'h1);
      rd(4'd0, v); check("R11 no acct flag", v, 32'h002);

      // R1: reset in the middle of a run
      wr(4'd2, 32'hFFF);
      pulse(12'h200);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(4'd1, v); check("R1 mask after reset", v, 32'hFFF);
      rd(4'd0, v); check("R1 status after reset", v, 32'h0);
      check("R1 irq after reset", {31'b0, irq}, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule